// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core

This block is a small 8-bit processor built around one accumulator. Every instruction finishes in a single clock period. The program counter addresses an external instruction store. That store returns a 12-bit word: a 4-bit opcode in bits 11:8 and an 8-bit field in bits 7:0. The field serves either as an immediate constant or as a data-store address. A combinational decoder turns the opcode into a small set of steering strobes. These strobes choose the operand, choose the ALU function, choose where the accumulator input comes from, choose the next program counter and control the data-store write.

All state changes on the falling clock edge: the program counter, the accumulator, the two condition flags and the external data write. Fetch, decode, operand selection and the ALU therefore settle while the clock is high. The result of an instruction appears on the ports in the cycle after it executes. Both the instruction store and the data store sit outside the block. The data store is read combinationally at the address in the field, and it is written on the falling edge while the active-low strobe is low.

Top module: `accCpu`

## Requirements
- R1: A synchronous reset, sampled on the falling edge, sets the program counter, the accumulator and both flags (sign and zero) to zero.
- R2: The instruction word puts the opcode in bits 11:8 and the field in bits 7:0. `imemAddr` always shows the program counter, and `dmemAddr` always shows the field of the current word.
- R3: Every opcode other than a taken jump advances the program counter by one, wrapping from 255 to 0.
- R4: Opcode 0000 loads the field into the accumulator. `dmemWdata` always presents the accumulator.
- R5: Opcode 0001 loads the data-store word at the field address into the accumulator.
- R6: Opcode 0010 drives `dmemWrN` low for that cycle, so the accumulator is stored at the field address, and it leaves the accumulator unchanged. Every other opcode holds `dmemWrN` high.
- R7: Opcodes 0011 (immediate) and 0100 (memory word) add the operand to the accumulator, modulo 256.
- R8: Opcodes 0101 (immediate) and 0110 (memory word) subtract the operand from the accumulator, modulo 256.
- R9: Opcodes 0111 (immediate) and 1000 (memory word) replace the accumulator with the low 8 bits of the product of the accumulator and the operand.
- R10: Opcodes 1001 (immediate) and 1010 (memory word) compare without changing the accumulator. The sign flag takes bit 7 of (accumulator minus operand) modulo 256, and the zero flag is set when that difference is zero. No other opcode changes the flags.
- R11: Opcode 1011 always loads the program counter from the field. Opcode 1100 does so only when the sign flag is set, and opcode 1101 only when the zero flag is set. When a conditional jump is not taken, the program counter advances by one.
- R12: Opcodes 1110 and 1111 are no-operations. They only advance the program counter.
- R13: State changes only on the falling edge. During an instruction's cycle the ports show the state from before it, and its result appears after the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 8 | Instruction store address (program counter) |
| imemData | input | 12 | Instruction word at `imemAddr` |
| dmemAddr | output | 8 | Data store address (instruction field) |
| dmemRdata | input | 8 | Data store word at `dmemAddr` |
| dmemWdata | output | 8 | Data to store (accumulator) |
| dmemWrN | output | 1 | Active-low data store write strobe |

## Verification
The hardest case to reach from the ports is a conditional jump whose outcome depends on flags written several instructions earlier. The flags cannot be seen directly, so the stimulus runs a compare, then an unrelated immediate load, then a jump on zero. This shows that only compares touch the flags. A second sequence sets the sign flag and then resets the core in the middle of a program. A jump on negative issued right after the reset must fall through, which is the only way to observe that reset cleared the flag. Finally, a factorial-of-4 loop ties everything together: its exit is decided by a compare that goes negative, and the bench checks that it leaves 24 at data address 100.

// File: rtl/accCpuPkg.sv
package accCpuPkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_LDI  = 4'h0;
  localparam logic [OP_W-1:0] OP_LDM  = 4'h1;
  localparam logic [OP_W-1:0] OP_ST   = 4'h2;
  localparam logic [OP_W-1:0] OP_ADDI = 4'h3;
  localparam logic [OP_W-1:0] OP_ADDM = 4'h4;
  localparam logic [OP_W-1:0] OP_SUBI = 4'h5;
  localparam logic [OP_W-1:0] OP_SUBM = 4'h6;
  localparam logic [OP_W-1:0] OP_MULI = 4'h7;
  localparam logic [OP_W-1:0] OP_MULM = 4'h8;
  localparam logic [OP_W-1:0] OP_CPI  = 4'h9;
  localparam logic [OP_W-1:0] OP_CPM  = 4'hA;
  localparam logic [OP_W-1:0] OP_JP   = 4'hB;
  localparam logic [OP_W-1:0] OP_JPN  = 4'hC;
  localparam logic [OP_W-1:0] OP_JPZ  = 4'hD;

  typedef enum logic [1:0] {
    PC_STEP    = 2'b00,
    PC_ALWAYS  = 2'b01,
    PC_IF_NEG  = 2'b10,
    PC_IF_ZERO = 2'b11
  } pcModeT;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_MUL = 2'b10,
    ALU_CMP = 2'b11
  } aluSelT;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    pcModeT pcMode;
    aluSelT aluSel;
    logic   accLoad;   // accumulator captures its input
    logic   bFromMem;  // operand B: 1 = data store word, 0 = field constant
    logic   accFromB;  // accumulator input: 1 = operand B, 0 = ALU result
    logic   wrN;       // active-low data store write
  } ctrlT;

  localparam ctrlT CTRL_IDLE = '{
    pcMode:   PC_STEP,
    aluSel:   ALU_ADD,
    accLoad:  1'b0,
    bFromMem: 1'b0,
    accFromB: 1'b0,
    wrN:      1'b1
  };

endpackage

// File: rtl/accCpuCtrl.sv
module accCpuCtrl
  import accCpuPkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output ctrlT            ctrl
);

  always_comb begin
    ctrl = CTRL_IDLE;
    case (opcode)
      OP_LDI: begin
        ctrl.accFromB = 1'b1;
        ctrl.accLoad  = 1'b1;
      end
      OP_LDM: begin
        ctrl.bFromMem = 1'b1;
        ctrl.accFromB = 1'b1;
        ctrl.accLoad  = 1'b1;
      end
      OP_ST: begin
        ctrl.wrN = 1'b0;
      end
      OP_ADDI, OP_ADDM: begin
        ctrl.bFromMem = (opcode == OP_ADDM);
        ctrl.aluSel   = ALU_ADD;
        ctrl.accLoad  = 1'b1;
      end
      OP_SUBI, OP_SUBM: begin
        ctrl.bFromMem = (opcode == OP_SUBM);
        ctrl.aluSel   = ALU_SUB;
        ctrl.accLoad  = 1'b1;
      end
      OP_MULI, OP_MULM: begin
        ctrl.bFromMem = (opcode == OP_MULM);
        ctrl.aluSel   = ALU_MUL;
        ctrl.accLoad  = 1'b1;
      end
      OP_CPI, OP_CPM: begin
        ctrl.bFromMem = (opcode == OP_CPM);
        ctrl.aluSel   = ALU_CMP;
      end
      OP_JP:   ctrl.pcMode = PC_ALWAYS;
      OP_JPN:  ctrl.pcMode = PC_IF_NEG;
      OP_JPZ:  ctrl.pcMode = PC_IF_ZERO;
      default: ctrl = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/accCpuAlu.sv
module accCpuAlu
  import accCpuPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  aluSelT            aluSel,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result
);

  always_comb begin
    case (aluSel)
      ALU_ADD: result = opA + opB;
      ALU_MUL: result = opA * opB;
      default: result = opA - opB;  // subtract and compare share the difference
    endcase
  end

endmodule

// File: rtl/accCpuDatapath.sv
module accCpuDatapath
  import accCpuPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlT              ctrl,
  input  logic [WORD_W-1:0] field,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] acc
);

  localparam logic [WORD_W-1:0] PC_ONE = WORD_W'(1);

  logic [WORD_W-1:0] opB;
  logic [WORD_W-1:0] aluResult;
  logic [WORD_W-1:0] accIn;
  logic [WORD_W-1:0] pcNext;
  logic              signFlag;
  logic              zeroFlag;
  logic              jumpTaken;

  assign opB   = ctrl.bFromMem ? memRdata : field;
  assign accIn = ctrl.accFromB ? opB : aluResult;

  accCpuAlu #(.WORD_W(WORD_W)) u_alu (
    .aluSel (ctrl.aluSel),
    .opA    (acc),
    .opB    (opB),
    .result (aluResult)
  );

  always_comb begin
    case (ctrl.pcMode)
      PC_ALWAYS:  jumpTaken = 1'b1;
      PC_IF_NEG:  jumpTaken = signFlag;
      PC_IF_ZERO: jumpTaken = zeroFlag;
      default:    jumpTaken = 1'b0;
    endcase
    pcNext = jumpTaken ? field : pc + PC_ONE;
  end

  // Everything settles while the clock is high and is captured on the fall.
  always_ff @(negedge clk) begin
    if (rst) begin
      pc       <= '0;
      acc      <= '0;
      signFlag <= 1'b0;
      zeroFlag <= 1'b0;
    end else begin
      pc <= pcNext;
      if (ctrl.accLoad) acc <= accIn;
      if (ctrl.aluSel == ALU_CMP) begin
        signFlag <= aluResult[WORD_W-1];
        zeroFlag <= (aluResult == '0);
      end
    end
  end

endmodule

// File: rtl/accCpu.sv
module accCpu
  import accCpuPkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [WORD_W-1:0]      imemAddr,
  input  logic [OP_W+WORD_W-1:0] imemData,
  output logic [WORD_W-1:0]      dmemAddr,
  input  logic [WORD_W-1:0]      dmemRdata,
  output logic [WORD_W-1:0]      dmemWdata,
  output logic                   dmemWrN
);

  localparam int INSTR_W = OP_W + WORD_W;

  ctrlT              ctrl;
  logic [OP_W-1:0]   opcode;
  logic [WORD_W-1:0] field;
  logic [WORD_W-1:0] pc;
  logic [WORD_W-1:0] acc;

  assign opcode = imemData[INSTR_W-1 -: OP_W];
  assign field  = imemData[WORD_W-1:0];

  accCpuCtrl u_ctrl (
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  accCpuDatapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .field    (field),
    .memRdata (dmemRdata),
    .pc       (pc),
    .acc      (acc)
  );

  assign imemAddr  = pc;
  assign dmemAddr  = field;
  assign dmemWdata = acc;
  assign dmemWrN   = ctrl.wrN;

endmodule

// File: rtl/accCpuChk.sv
module accCpuChk
  import accCpuPkg::*;
#(
  parameter int WORD_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [WORD_W-1:0]      imemAddr,
  input logic [OP_W+WORD_W-1:0] imemData,
  input logic [WORD_W-1:0]      dmemWdata,
  input logic                   dmemWrN
);

  localparam int INSTR_W = OP_W + WORD_W;

  logic [OP_W-1:0]   op;
  logic [WORD_W-1:0] fld;
  logic              stepsOnly;

  assign op        = imemData[INSTR_W-1 -: OP_W];
  assign fld       = imemData[WORD_W-1:0];
  assign stepsOnly = (op < OP_JP) || (op > OP_JPZ);

  // R1: reset leaves program counter and accumulator at zero
  assert_reset_clears_R1: assert property (@(negedge clk)
    rst |=> (imemAddr == '0) && (dmemWdata == '0));

  // R6: store opcode pulls the strobe low, all others keep it high
  assert_store_strobe_R6: assert property (@(negedge clk) disable iff (rst)
    (op == OP_ST) |-> !dmemWrN);
  assert_no_stray_write_R6: assert property (@(negedge clk) disable iff (rst)
    (op != OP_ST) |-> dmemWrN);

  // R6: a store leaves the accumulator as it was
  assert_store_keeps_acc_R6: assert property (@(negedge clk) disable iff (rst)
    (op == OP_ST) |=> $stable(dmemWdata));

  // R3: non-jump opcodes advance the program counter by one
  assert_pc_step_R3: assert property (@(negedge clk) disable iff (rst)
    stepsOnly |=> imemAddr == WORD_W'($past(imemAddr) + 1'b1));

  // R11: unconditional jump lands on the field
  assert_jump_target_R11: assert property (@(negedge clk) disable iff (rst)
    (op == OP_JP) |=> imemAddr == $past(fld));

  // R4: immediate load shows the field on the accumulator next cycle
  assert_load_imm_R4: assert property (@(negedge clk) disable iff (rst)
    (op == OP_LDI) |=> dmemWdata == $past(fld));

endmodule

bind accCpu accCpuChk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imemAddr  (imemAddr),
  .imemData  (imemData),
  .dmemWdata (dmemWdata),
  .dmemWrN   (dmemWrN)
);

// File: tb/accCpu_bench.sv
`timescale 1ns/1ps
module accCpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imemAddr;
  logic [11:0] imemData;
  logic [7:0]  dmemAddr;
  logic [7:0]  dmemRdata;
  logic [7:0]  dmemWdata;
  logic        dmemWrN;

  logic [11:0] imem [256];
  logic [7:0]  dmem [256];

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;  // 50 MHz

  accCpu u_accCpu (
    .clk       (clk),
    .rst       (rst),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemRdata (dmemRdata),
    .dmemWdata (dmemWdata),
    .dmemWrN   (dmemWrN)
  );

  assign imemData  = imem[imemAddr];
  assign dmemRdata = dmem[dmemAddr];

  always @(negedge clk) begin
    if (!dmemWrN) dmem[dmemAddr] = dmemWdata;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 12'hE00;
      dmem[i] = 8'h00;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic testReset();
    clearMem();
    imem[0] = 12'hC40;  // jump if negative
    imem[1] = 12'hD40;  // jump if zero
    imem[2] = 12'h005;  // load 5
    imem[3] = 12'h906;  // compare 6 -> sign set
    imem[4] = 12'hE00;
    doReset();
    chk("R1", "pc after reset", imemAddr, 0);
    chk("R1", "acc after reset", dmemWdata, 0);
    step();
    chk("R1", "sign clear, no jump", imemAddr, 1);
    step();
    chk("R1", "zero clear, no jump", imemAddr, 2);
    step(); step();
    chk("R10", "compare keeps acc", dmemWdata, 5);
    doReset();
    chk("R1", "pc after mid-run reset", imemAddr, 0);
    chk("R1", "acc after mid-run reset", dmemWdata, 0);
    step();
    chk("R1", "sign cleared by reset", imemAddr, 1);
  endtask

  task automatic testLoadStore();
    clearMem();
    dmem[8'h30] = 8'h9A;
    imem[0] = 12'h03C;  // load 0x3C
    imem[1] = 12'h240;  // store 0x40
    imem[2] = 12'h130;  // load mem 0x30
    imem[3] = 12'h241;  // store 0x41
    doReset();
    chk("R13", "acc before first fall", dmemWdata, 0);
    chk("R6", "strobe high on load", dmemWrN, 1);
    step();
    chk("R4", "immediate load", dmemWdata, 8'h3C);
    chk("R6", "strobe low on store", dmemWrN, 0);
    chk("R2", "data address is field", dmemAddr, 8'h40);
    chk("R2", "fetch address", imemAddr, 1);
    step();
    chk("R6", "stored word", dmem[8'h40], 8'h3C);
    chk("R6", "acc kept by store", dmemWdata, 8'h3C);
    chk("R13", "acc before memory load lands", dmemWdata, 8'h3C);
    step();
    chk("R5", "memory load", dmemWdata, 8'h9A);
    step();
    chk("R6", "second stored word", dmem[8'h41], 8'h9A);
  endtask

  task automatic testArith();
    clearMem();
    dmem[8'h50] = 8'h07;
    dmem[8'h51] = 8'h20;
    imem[0] = 12'h0F0;
    imem[1] = 12'h320;
    imem[2] = 12'h450;
    imem[3] = 12'h518;
    imem[4] = 12'h651;
    imem[5] = 12'h014;
    imem[6] = 12'h70D;
    imem[7] = 12'h850;
    doReset();
    step();
    step(); chk("R7", "add immediate wraps", dmemWdata, 8'h10);
    step(); chk("R7", "add memory", dmemWdata, 8'h17);
    step(); chk("R8", "subtract immediate wraps", dmemWdata, 8'hFF);
    step(); chk("R8", "subtract memory", dmemWdata, 8'hDF);
    step();
    step(); chk("R9", "multiply immediate low byte", dmemWdata, 8'h04);
    step(); chk("R9", "multiply memory", dmemWdata, 8'h1C);
  endtask

  task automatic testCompareJump();
    clearMem();
    dmem[8'h52] = 8'h05;
    imem[8'h00] = 12'h005;
    imem[8'h01] = 12'h906;  // 5-6 negative
    imem[8'h02] = 12'hD20;
    imem[8'h03] = 12'hC10;
    imem[8'h10] = 12'hA52;  // 5-5 zero
    imem[8'h11] = 12'hC30;
    imem[8'h12] = 12'hD40;
    imem[8'h40] = 12'h009;  // load, flags untouched
    imem[8'h41] = 12'hD60;
    imem[8'h60] = 12'hB07;
    doReset();
    step();
    step(); chk("R10", "compare keeps acc", dmemWdata, 5);
    step(); chk("R11", "zero jump not taken", imemAddr, 3);
    step(); chk("R11", "negative jump taken", imemAddr, 8'h10);
    step(); chk("R10", "memory compare keeps acc", dmemWdata, 5);
    step(); chk("R11", "negative jump not taken", imemAddr, 8'h12);
    step(); chk("R11", "zero jump taken", imemAddr, 8'h40);
    step(); chk("R4", "load between compare and jump", dmemWdata, 9);
    step(); chk("R10", "zero flag kept across load", imemAddr, 8'h60);
    step(); chk("R11", "unconditional jump", imemAddr, 8'h07);
  endtask

  task automatic testNopWrap();
    clearMem();
    dmem[8'h55] = 8'h11;
    dmem[8'hAA] = 8'h22;
    imem[8'h00] = 12'h077;
    imem[8'h01] = 12'hBFE;
    imem[8'hFE] = 12'hE55;
    imem[8'hFF] = 12'hFAA;
    doReset();
    step(); step();
    chk("R12", "strobe high on opcode 1110", dmemWrN, 1);
    step();
    chk("R12", "opcode 1110 steps pc", imemAddr, 8'hFF);
    chk("R12", "opcode 1110 keeps acc", dmemWdata, 8'h77);
    chk("R12", "strobe high on opcode 1111", dmemWrN, 1);
    step();
    chk("R3", "pc wraps to zero", imemAddr, 0);
    chk("R12", "opcode 1111 keeps acc", dmemWdata, 8'h77);
    chk("R12", "no write at 0x55", dmem[8'h55], 8'h11);
    chk("R12", "no write at 0xAA", dmem[8'hAA], 8'h22);
  endtask

  task automatic testFactorial();
    clearMem();
    imem[0]  = 12'h004;  // load 4
    imem[1]  = 12'h264;  // store 100
    imem[2]  = 12'h501;  // subtract 1
    imem[3]  = 12'h265;  // store 101
    imem[4]  = 12'h902;  // compare 2
    imem[5]  = 12'hC0C;  // exit if negative
    imem[6]  = 12'h864;  // multiply by [100]
    imem[7]  = 12'h264;  // store 100
    imem[8]  = 12'h165;  // load [101]
    imem[9]  = 12'hB02;  // loop
    imem[12] = 12'hB0C;  // park
    doReset();
    repeat (40) step();
    chk("R9", "factorial result at 100", dmem[100], 24);
    chk("R11", "loop exit address", imemAddr, 12);
    chk("R8", "last counter at 101", dmem[101], 1);
  endtask

  initial begin
    clearMem();
    testReset();
    testLoadStore();
    testArith();
    testCompareJump();
    testNopWrap();
    testFactorial();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule